// File: doc/BRIEF.md
# Safe-State Entry Sequencer with Recovery Counter

This block sits in the control logic of a power-management device. When a fault request arrives while the device is in its mission state, it shuts the device down in one of two ways and brings it into a safe state. A severe request cuts switching at once and pulls every output to ground through its discharge resistor. A normal request only turns the rails off. After power-down, the sequencer runs a short script of masked register writes over a simple request/done bus. Each write is a read, then a bit merge, then a write back. After a severe shutdown the sequencer can also hold for a fixed number of one-millisecond ticks, and recovery cannot start until that hold ends.

When the sequence is over, a saturating recovery counter advances and is compared with a programmable threshold. If the new count is below the threshold, the block pulses a recovery-attempt output and returns to the mission state. If it is not below, the block latches a lockout that only a power-on reset clears. A severe request that arrives during a normal shutdown raises the pulldowns at once and adds the post-sequence hold. Any other request made during a shutdown is ignored.

Top module: `ssq_safe_seq`

## Requirements
- R1: After reset, every rail enable, every buck switching enable and the driver enable are 1, every pulldown enable is 0, lockout and recov_try are 0, recov_cnt is 0 and bus_req is 0.
- R2: A fault_req sampled high at a clock edge in the mission state drives all rail_en bits, all buck_sw_en bits and drv_en to 0 together from the next cycle until the block returns to the mission state.
- R3: After a severe request (fault_sev=1), all pd_en bits are 1 from the same cycle that the rails drop, and they stay 1 until the cycle after the recovery-attempt pulse. After a normal request, pd_en stays 0.
- R4: Each script step reads one address, then writes that address with (old & keep) | (data & ~keep), where keep bits set to 1 preserve the old bit. Address and direction hold steady while a request waits for bus_done, and a step begins only after the previous write has seen bus_done.
- R5: No bus request is made in the mission state. Both flavours first update address 0x81 with data 0x04 and keep 0xE3. The normal flavour then updates address 0x87 with data 0x1F and keep 0xE0, so the buck reset always comes after the rails are off.
- R6: With the hold option enabled, after a severe script the block waits for DLY_MS (default 500) tick_1ms pulses. A tick in the cycle that enters the hold is not counted. The count update happens on the edge that follows the last tick.
- R7: At the end of each sequence, recov_cnt rises by one, saturating at its maximum. If the new count is below recov_thr, recov_try is high for exactly one cycle and the block then returns to the mission state. Otherwise lockout rises.
- R8: Once lockout is high it stays high, with rails, driver and switching off, and every fault request is ignored until reset.
- R9: A fault request during a shutdown, the hold or the recovery decision is ignored. The exception is a severe request during the power-down or script phase of a normal shutdown: it raises all pd_en bits on the next cycle and makes the hold apply.
- R10: A normal shutdown has no hold. The count update happens in the cycle right after the final script write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| fault_req | input | 1 | Request to enter the safe state, sampled each edge |
| fault_sev | input | 1 | 1 = severe flavour, 0 = normal, qualified by fault_req |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| recov_thr | input | CNT_W | Recovery count at which lockout is taken |
| rail_en | output | N_BUCK+N_LDO | Per-rail enable, bucks in the low bits |
| drv_en | output | 1 | External driver enable |
| buck_sw_en | output | N_BUCK | Per-buck switching enable |
| pd_en | output | N_BUCK+N_LDO | Per-rail output pulldown enable |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Merged write data |
| bus_rdata | input | DW | Read data, valid when bus_done is high on a read |
| bus_done | input | 1 | Transfer completes at the edge where it is high with bus_req |
| recov_try | output | 1 | One-cycle recovery-attempt pulse |
| lockout | output | 1 | Sticky recovery lockout |
| recov_cnt | output | CNT_W | Recovery counter value |

## Verification
A wrong sequencer state shows up on rail_en, drv_en or pd_en in the first cycle after the edge that caused it, because these outputs are decoded directly from the state. A script that is misordered or merged wrongly shows up on bus_addr and bus_wdata at the completing edge of the affected transfer. A hold counter that is off by any amount moves the recovery pulse by whole tick periods, and a counter or threshold error changes recov_cnt, recov_try or lockout one cycle after the sequence ends. The reference model tracks the expected state through each transfer and tick, so any of these errors is seen on the first clock where it appears.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [2:0] {
      SQ_ACTIVE  = 3'd0,
      SQ_OFF     = 3'd1,
      SQ_SCRIPT  = 3'd2,
      SQ_DELAY   = 3'd3,
      SQ_COUNT   = 3'd4,
      SQ_ATTEMPT = 3'd5,
      SQ_LOCK    = 3'd6
   } sq_state_e;

   typedef enum logic [1:0] {
      RMW_IDLE = 2'd0,
      RMW_RD   = 2'd1,
      RMW_WR   = 2'd2
   } rmw_state_e;

   // script constants, 8-bit register space
   localparam logic [7:0] CFG_ADDR     = 8'h81;
   localparam logic [7:0] CFG_DATA     = 8'h04;
   localparam logic [7:0] CFG_KEEP     = 8'hE3;
   localparam logic [7:0] BRST_ADDR    = 8'h87;
   localparam logic [7:0] BRST_DATA    = 8'h1F;
   localparam logic [7:0] BRST_KEEP    = 8'hE0;
   localparam logic [7:0] BRST_DATA_S  = 8'h0F;
   localparam logic [7:0] BRST_KEEP_S  = 8'hF0;

endpackage

// File: rtl/ssq_script.sv
module ssq_script
   import ssq_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter bit SHORT_SCRIPT = 1'b0
) (
   input  logic          flav_sev,
   input  logic [1:0]    idx,
   output logic [1:0]    n_steps,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data,
   output logic [DW-1:0] keep
);

   generate
      if (SHORT_SCRIPT) begin : g_short
         // single buck-reset step, normal flavour only
         wire unused_idx = ^idx;
         assign n_steps = flav_sev ? 2'd0 : 2'd1;
         assign addr    = AW'(BRST_ADDR);
         assign data    = DW'(BRST_DATA_S);
         assign keep    = DW'(BRST_KEEP_S);
      end else begin : g_full
         assign n_steps = flav_sev ? 2'd1 : 2'd2;
         always_comb begin
            if (idx == 2'd0) begin
               addr = AW'(CFG_ADDR);
               data = DW'(CFG_DATA);
               keep = DW'(CFG_KEEP);
            end else begin
               addr = AW'(BRST_ADDR);
               data = DW'(BRST_DATA);
               keep = DW'(BRST_KEEP);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ssq_rmw_master.sv
module ssq_rmw_master
   import ssq_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] step_addr,
   input  logic [DW-1:0] step_data,
   input  logic [DW-1:0] step_keep,
   output logic          step_done,
   output logic          bus_req,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_done
);

   rmw_state_e    st_q;
   logic [DW-1:0] old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RMW_IDLE;
         old_q <= '0;
      end else begin
         unique case (st_q)
            RMW_IDLE: if (go) st_q <= RMW_RD;
            RMW_RD: if (bus_done) begin
               old_q <= bus_rdata;
               st_q  <= RMW_WR;
            end
            RMW_WR: if (bus_done) st_q <= RMW_IDLE;
            default: st_q <= RMW_IDLE;
         endcase
      end
   end

   assign bus_req   = (st_q != RMW_IDLE);
   assign bus_we    = (st_q == RMW_WR);
   assign bus_addr  = step_addr;
   assign bus_wdata = (old_q & step_keep) | (step_data & ~step_keep);
   assign step_done = (st_q == RMW_WR) && bus_done;

   // R4: a waiting request holds address, direction and data
   a_r4_req_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_done) |=> (bus_req && bus_addr == $past(bus_addr)
                                  && bus_we == $past(bus_we)
                                  && bus_wdata == $past(bus_wdata)));

   // R4: a completed read is followed by the write of the same step
   a_r4_write_follows_read : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_done) |=> (bus_req && bus_we));

endmodule

// File: rtl/ssq_ms_timer.sv
module ssq_ms_timer #(
   parameter int DLY_MS = 500,
   parameter int DLY_W  = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   input  logic tick,
   output logic expire
);

   localparam logic [DLY_W-1:0] LOAD_VAL = DLY_W'(DLY_MS);

   logic [DLY_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             left_q <= '0;
      else if (load)                          left_q <= LOAD_VAL;
      else if (run && tick && left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign expire = run && tick && (left_q == DLY_W'(1));

   // R6: each hold starts from the full count
   a_r6_reload : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (left_q == LOAD_VAL));

   // R6: only ticks move the count
   a_r6_tick_only : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(left_q));

endmodule

// File: rtl/ssq_recov_ctr.sv
module ssq_recov_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   input  logic [CNT_W-1:0] thr,
   output logic [CNT_W-1:0] cnt,
   output logic             reached
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   assign reached = (cnt_nxt >= thr);
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (bump) cnt_q <= cnt_nxt;
   end

   // R7: one step per sequence end
   a_r7_count_step : assert property (@(posedge clk) disable iff (!rst_n)
      (bump && cnt_q != CNT_MAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R7: no movement without a sequence end, and no wrap
   a_r7_count_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!bump || cnt_q == CNT_MAX) |=> $stable(cnt_q));

endmodule

// File: rtl/ssq_safe_seq.sv
module ssq_safe_seq
   import ssq_pkg::*;
#(
   parameter int N_BUCK       = 5,
   parameter int N_LDO        = 4,
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter int CNT_W        = 4,
   parameter int DLY_MS       = 500,
   parameter int DLY_W        = 9,
   parameter bit SEV_DELAY_EN = 1'b1,
   parameter bit SHORT_SCRIPT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fault_req,
   input  logic                    fault_sev,
   input  logic                    tick_1ms,
   input  logic [CNT_W-1:0]        recov_thr,
   output logic [N_BUCK+N_LDO-1:0] rail_en,
   output logic                    drv_en,
   output logic [N_BUCK-1:0]       buck_sw_en,
   output logic [N_BUCK+N_LDO-1:0] pd_en,
   output logic                    bus_req,
   output logic                    bus_we,
   output logic [AW-1:0]           bus_addr,
   output logic [DW-1:0]           bus_wdata,
   input  logic [DW-1:0]           bus_rdata,
   input  logic                    bus_done,
   output logic                    recov_try,
   output logic                    lockout,
   output logic [CNT_W-1:0]        recov_cnt
);

   localparam int N_RAIL = N_BUCK + N_LDO;

   // elaboration-time parameter checks
   if (N_BUCK < 1 || N_LDO < 0) begin : g_bad_rails
      $error("ssq_safe_seq: rail counts out of range");
   end
   if (AW < 8 || DW < 8) begin : g_bad_bus
      $error("ssq_safe_seq: bus must be at least 8 bits wide");
   end
   if (DLY_MS < 1 || DLY_MS >= (1 << DLY_W)) begin : g_bad_dly
      $error("ssq_safe_seq: hold length does not fit DLY_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ssq_safe_seq: CNT_W must be positive");
   end

   sq_state_e     st_q, st_nxt, tail_st;
   logic          sev_q, flav_q;
   logic [1:0]    idx_q;
   logic [1:0]    n_steps;
   logic          last_step, step_done, in_seq;
   logic          dly_expire, cnt_reached;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_data, s_keep;
   logic          mission, pd_on;

   ssq_script #(.AW(AW), .DW(DW), .SHORT_SCRIPT(SHORT_SCRIPT)) script_i (
      .flav_sev (flav_q),
      .idx      (idx_q),
      .n_steps  (n_steps),
      .addr     (s_addr),
      .data     (s_data),
      .keep     (s_keep)
   );

   ssq_rmw_master #(.AW(AW), .DW(DW)) rmw_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (st_q == SQ_SCRIPT),
      .step_addr (s_addr),
      .step_data (s_data),
      .step_keep (s_keep),
      .step_done (step_done),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_done  (bus_done)
   );

   generate
      if (SEV_DELAY_EN) begin : g_hold
         ssq_ms_timer #(.DLY_MS(DLY_MS), .DLY_W(DLY_W)) timer_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (st_q != SQ_DELAY && st_nxt == SQ_DELAY),
            .run    (st_q == SQ_DELAY),
            .tick   (tick_1ms),
            .expire (dly_expire)
         );
      end else begin : g_no_hold
         wire unused_tick = tick_1ms;
         assign dly_expire = 1'b0;
      end
   endgenerate

   ssq_recov_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bump    (st_q == SQ_COUNT),
      .thr     (recov_thr),
      .cnt     (recov_cnt),
      .reached (cnt_reached)
   );

   assign last_step = (idx_q == n_steps - 2'd1);
   assign in_seq    = (st_q == SQ_OFF) || (st_q == SQ_SCRIPT);
   assign tail_st   = (sev_q && SEV_DELAY_EN) ? SQ_DELAY : SQ_COUNT;

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         SQ_ACTIVE:  if (fault_req) st_nxt = SQ_OFF;
         SQ_OFF:     st_nxt = (n_steps != 2'd0) ? SQ_SCRIPT : tail_st;
         SQ_SCRIPT:  if (step_done && last_step) st_nxt = tail_st;
         SQ_DELAY:   if (dly_expire) st_nxt = SQ_COUNT;
         SQ_COUNT:   st_nxt = cnt_reached ? SQ_LOCK : SQ_ATTEMPT;
         SQ_ATTEMPT: st_nxt = SQ_ACTIVE;
         SQ_LOCK:    st_nxt = SQ_LOCK;
         default:    st_nxt = SQ_LOCK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_ACTIVE;
         sev_q  <= 1'b0;
         flav_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         st_q <= st_nxt;
         if (st_q == SQ_ACTIVE && fault_req) begin
            sev_q  <= fault_sev;
            flav_q <= fault_sev;
            idx_q  <= '0;
         end else if (in_seq && fault_req && fault_sev) begin
            sev_q <= 1'b1;
         end else if (st_q == SQ_ATTEMPT) begin
            sev_q <= 1'b0;
         end
         if (st_q == SQ_SCRIPT && step_done && !last_step) idx_q <= idx_q + 2'd1;
      end
   end

   assign mission   = (st_q == SQ_ACTIVE);
   assign pd_on     = sev_q && !mission;
   assign drv_en    = mission;
   assign recov_try = (st_q == SQ_ATTEMPT);
   assign lockout   = (st_q == SQ_LOCK);

   for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
      assign rail_en[g] = mission;
      assign pd_en[g]   = pd_on;
   end
   for (genvar g = 0; g < N_BUCK; g++) begin : g_buck
      assign buck_sw_en[g] = mission;
   end

   // R2: an accepted request drops every rail and the driver together
   a_r2_all_off : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_ACTIVE && fault_req) |=> (rail_en == '0 && !drv_en && buck_sw_en == '0));

   // R5: the register bus is quiet in the mission state
   a_r5_quiet_mission : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_ACTIVE) |-> !bus_req);

   // R9: severe escalation during a shutdown raises the pulldowns next cycle
   a_r9_escalate : assert property (@(posedge clk) disable iff (!rst_n)
      (in_seq && fault_req && fault_sev) |=> (pd_en == '1));

   // R8: lockout is sticky
   a_r8_lock_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      lockout |=> (lockout && rail_en == '0));

   // R7: a recovery attempt is one cycle and returns to the mission state
   a_r7_try_returns : assert property (@(posedge clk) disable iff (!rst_n)
      recov_try |=> (!recov_try && rail_en == '1 && drv_en));

endmodule

// File: tb/ssq_safe_seq_tb_top.sv
`timescale 1ns/1ps
module ssq_safe_seq_tb_top;

   localparam int NR   = 9;
   localparam int NB   = 5;
   localparam int HOLD = 500;

   localparam int P_ACT = 0, P_OFF = 1, P_SEQ = 2, P_DLY = 3,
                  P_REC = 4, P_TRY = 5, P_LCK = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fault_req, fault_sev, tick_1ms;
   logic [3:0]    recov_thr;
   logic [NR-1:0] rail_en, pd_en;
   logic          drv_en;
   logic [NB-1:0] buck_sw_en;
   logic          bus_req, bus_we, bus_done;
   logic [7:0]    bus_addr, bus_wdata, bus_rdata;
   logic          recov_try, lockout;
   logic [3:0]    recov_cnt;

   int n_chk = 0, n_fail = 0;
   bit run_chk = 0, done_flag = 0;

   always #10 clk = ~clk;

   ssq_safe_seq dut_i (
      .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .fault_sev(fault_sev),
      .tick_1ms(tick_1ms), .recov_thr(recov_thr), .rail_en(rail_en),
      .drv_en(drv_en), .buck_sw_en(buck_sw_en), .pd_en(pd_en),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
      .recov_try(recov_try), .lockout(lockout), .recov_cnt(recov_cnt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // register-bus responder with its own register image
   logic [7:0] mem [0:255];
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[8'h81] = 8'h5A;
      mem[8'h87] = 8'hC3;
   end
   assign bus_rdata = mem[bus_addr];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_done <= 1'b0;
      else begin
         bus_done <= bus_req && !bus_done;
         if (bus_req && bus_we && bus_done) mem[bus_addr] <= bus_wdata;
      end
   end

   // millisecond tick: one cycle in eight
   initial begin
      tick_1ms = 1'b0;
      forever begin
         repeat (7) @(negedge clk);
         tick_1ms = 1'b1;
         @(negedge clk);
         tick_1ms = 1'b0;
      end
   end

   // reference model
   int ph = P_ACT, sev = 0, dly = 0, cnt = 0, oph, osev;
   logic [23:0] wq[$];
   logic [7:0]  exp_w;

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = P_ACT; sev = 0; cnt = 0; dly = 0;
         wq.delete();
      end else begin
         oph = ph; osev = sev;
         if (bus_req && bus_done) begin
            if (wq.size() == 0) begin
               chk(1'b0, "R4 unexpected transfer", bus_addr, 0);
            end else if (!bus_we) begin
               chk(bus_addr == wq[0][23:16], "R5 read address", bus_addr, wq[0][23:16]);
            end else begin
               exp_w = (mem[bus_addr] & wq[0][7:0]) | (wq[0][15:8] & ~wq[0][7:0]);
               chk(bus_addr == wq[0][23:16], "R5 write address", bus_addr, wq[0][23:16]);
               chk(bus_wdata == exp_w, "R4 merged write data", bus_wdata, exp_w);
               void'(wq.pop_front());
               if (wq.size() == 0 && oph == P_SEQ) begin
                  if (osev != 0) begin ph = P_DLY; dly = HOLD; end
                  else ph = P_REC;
               end
            end
         end
         case (oph)
            P_ACT: if (fault_req) begin
               ph = P_OFF;
               sev = int'(fault_sev);
               wq.push_back({8'h81, 8'h04, 8'hE3});
               if (!fault_sev) wq.push_back({8'h87, 8'h1F, 8'hE0});
            end
            P_OFF: if (wq.size() == 0) begin
               if (osev != 0) begin ph = P_DLY; dly = HOLD; end
               else ph = P_REC;
            end else ph = P_SEQ;
            P_DLY: if (tick_1ms) begin
               if (dly == 1) ph = P_REC;
               else dly--;
            end
            P_REC: begin
               cnt = (cnt == 15) ? 15 : cnt + 1;
               ph  = (cnt >= int'(recov_thr)) ? P_LCK : P_TRY;
            end
            P_TRY: begin ph = P_ACT; sev = 0; end
            default: ;
         endcase
         if ((oph == P_OFF || oph == P_SEQ) && fault_req && fault_sev) sev = 1;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (run_chk) begin
         chk(rail_en == ((ph == P_ACT) ? {NR{1'b1}} : {NR{1'b0}}), "R2 rail_en",
             rail_en, (ph == P_ACT) ? 9'h1FF : 0);
         chk(drv_en == (ph == P_ACT), "R2 drv_en", drv_en, ph == P_ACT);
         chk(buck_sw_en == ((ph == P_ACT) ? {NB{1'b1}} : {NB{1'b0}}), "R2 buck_sw_en",
             buck_sw_en, (ph == P_ACT) ? 5'h1F : 0);
         chk(pd_en == ((sev != 0 && ph != P_ACT) ? {NR{1'b1}} : {NR{1'b0}}),
             "R3/R9 pd_en", pd_en, (sev != 0 && ph != P_ACT) ? 9'h1FF : 0);
         chk(recov_try == (ph == P_TRY), "R6/R7 recov_try", recov_try, ph == P_TRY);
         chk(lockout == (ph == P_LCK), "R8 lockout", lockout, ph == P_LCK);
         chk(int'(recov_cnt) == cnt, "R7/R10 recov_cnt", recov_cnt, cnt);
         if (ph != P_SEQ)
            chk(!bus_req, "R5 bus quiet outside script", bus_req, 0);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic req(input bit s);
      @(negedge clk);
      fault_req = 1'b1;
      fault_sev = s;
      @(negedge clk);
      fault_req = 1'b0;
      fault_sev = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; fault_req = 1'b0; fault_sev = 1'b0; recov_thr = 4'd5;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      run_chk = 1;
      // R1 reset state
      chk(rail_en == 9'h1FF && drv_en && buck_sw_en == 5'h1F, "R1 rails on after reset",
          rail_en, 9'h1FF);
      chk(pd_en == 0 && !lockout && !recov_try && recov_cnt == 0 && !bus_req,
          "R1 idle outputs after reset", {pd_en, lockout, recov_try, recov_cnt}, 0);

      // normal shutdown, no hold (R10), recovery attempt
      req(1'b0);
      cyc(40);
      chk(recov_cnt == 4'd1 && rail_en == 9'h1FF, "R10 normal sequence recovered",
          recov_cnt, 1);

      // severe shutdown with hold, requests during it ignored (R9)
      req(1'b1);
      cyc(4);
      req(1'b0);
      cyc(200);
      req(1'b1);
      cyc(300);
      chk(rail_en == 0 && pd_en == 9'h1FF && recov_cnt == 4'd1, "R6 still holding",
          recov_cnt, 1);
      cyc(3800);
      chk(recov_cnt == 4'd2 && rail_en == 9'h1FF, "R6 hold ended and recovered",
          recov_cnt, 2);

      // normal shutdown escalated to severe (R9)
      req(1'b0);
      cyc(3);
      req(1'b1);
      cyc(4300);
      chk(recov_cnt == 4'd3 && rail_en == 9'h1FF, "R9 escalated sequence recovered",
          recov_cnt, 3);

      // another severe, then the normal one reaching the threshold
      req(1'b1);
      cyc(4300);
      req(1'b0);
      cyc(40);
      chk(lockout && recov_cnt == 4'd5, "R7 threshold reached", recov_cnt, 5);
      req(1'b1);
      cyc(30);
      chk(lockout && rail_en == 0 && !drv_en, "R8 lockout ignores requests", lockout, 1);

      // threshold of one locks on the first sequence
      @(negedge clk);
      run_chk = 0;
      rst_n = 1'b0;
      recov_thr = 4'd1;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      run_chk = 1;
      chk(!lockout && recov_cnt == 0, "R1 reset clears lockout", lockout, 0);
      req(1'b0);
      cyc(40);
      chk(lockout && recov_cnt == 4'd1, "R7 threshold one locks at once", recov_cnt, 1);
      cyc(5);
      finish_run();
   end

endmodule